// File: doc/BRIEF.md
# Bidirectional Dual-Clock FIFO Pair

The block joins two clock domains, port A and port B, through two independent first-in first-out queues that carry data in opposite directions. The A-to-B lane is written from the A side and read on the B side. The B-to-A lane is written from the B side and read on the A side. Each lane holds 64 words of 36 bits by default.

Each port has one set of control lines: an active-low select, a direction bit, a mailbox bit and an enable. The port decodes these lines into a push onto its outgoing lane or a pop from its incoming lane. An access with the mailbox bit set performs no queue operation.

Write and read pointers cross between the domains as Gray code through multi-flop synchronizers. Each reader computes its word count in its own clock domain. From that count it drives an empty flag and an active-low almost-empty flag with a fixed threshold. The full flag for each lane is driven in that lane's writer domain.

Top module: `bidir_fifo_pair`

## Requirements
- R1: A port A access with sel_a_n=0, wr_rd_a=1, mbox_a=0 and en_a=1 pushes din_a onto the A-to-B lane on the rising clk_a edge.
- R2: A port B access with sel_b_n=0, wr_rd_b=0, mbox_b=0 and en_b=1 pops the A-to-B lane on the rising clk_b edge. While empty_b is 0, dout_b shows the oldest unread word, and words leave in the order they were pushed.
- R3: The B-to-A lane mirrors R1 and R2 with the ports swapped. Port B pushes din_b with wr_rd_b=1, and port A pops with wr_rd_a=0. The lane then drives dout_a, empty_a and nearly_empty_n_a.
- R4: An access with the mailbox bit at 1, the select at 1 or the enable at 0 performs no push and no pop.
- R5: A lane takes 64 words. After 64 pushes with no pop, the writer's full flag (full_a for the A-to-B lane) is 1. A push while that flag is 1 is ignored and stores nothing.
- R6: A pop while the reader's empty flag is 1 is ignored and leaves the lane's pointers unchanged.
- R7: nearly_empty_n_b is 0 while the A-to-B lane holds 8 (the parameter AE_OFFSET) or fewer words, and 1 while it holds 9 or more. nearly_empty_n_a follows the same rule for the B-to-A lane.
- R8: After a push raises a lane's count from AE_OFFSET to AE_OFFSET+1, the reader's almost-empty flag is still 0 after the first following reader edge. It goes to 1 after the second reader edge, or after the third when the clock edges fall too close together.
- R9: While a reader's reset is low, that reader's empty flag is 1 and its almost-empty flag is 0. The full flags are 0 after reset.
- R10: Whenever a reader's empty flag is 1, its almost-empty flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A active-low asynchronous reset |
| sel_a_n | input | 1 | Port A select, active low |
| wr_rd_a | input | 1 | Port A direction: 1 pushes, 0 pops |
| mbox_a | input | 1 | Port A mailbox select; 1 means no queue operation |
| en_a | input | 1 | Port A enable |
| din_a | input | 36 | Data pushed onto the A-to-B lane |
| dout_a | output | 36 | Head word of the B-to-A lane |
| full_a | output | 1 | A-to-B lane full, in the clk_a domain |
| empty_a | output | 1 | B-to-A lane empty, in the clk_a domain |
| nearly_empty_n_a | output | 1 | B-to-A lane holds more than AE_OFFSET words |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B active-low asynchronous reset |
| sel_b_n | input | 1 | Port B select, active low |
| wr_rd_b | input | 1 | Port B direction: 1 pushes, 0 pops |
| mbox_b | input | 1 | Port B mailbox select; 1 means no queue operation |
| en_b | input | 1 | Port B enable |
| din_b | input | 36 | Data pushed onto the B-to-A lane |
| dout_b | output | 36 | Head word of the A-to-B lane |
| full_b | output | 1 | B-to-A lane full, in the clk_b domain |
| empty_b | output | 1 | A-to-B lane empty, in the clk_b domain |
| nearly_empty_n_b | output | 1 | A-to-B lane holds more than AE_OFFSET words |

## Verification
The assertions check four properties on every cycle. The almost-empty flag is never high while empty is high. The head word holds still while a lane is non-empty and not popped. A full flag rises only after a push. The reset values of the flags hold. Only the scenarios can show the rest: word order across the crossing, the exact 64-word capacity, ignored pushes when full and pops when empty, mailbox accesses doing nothing, and the two-or-three-edge latency of the almost-empty flag at the threshold.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
   typedef struct packed {
      logic sel_n;
      logic wr_rd;
      logic mbox;
      logic en;
   } port_ctl_t;
endpackage

// File: rtl/port_decode.sv
module port_decode
   import fifo_pair_pkg::*;
(
   input  port_ctl_t ctl,
   output logic      push,
   output logic      pop
);
   logic live;
   always_comb begin
      live = !ctl.sel_n && !ctl.mbox && ctl.en;
      push = live && ctl.wr_rd;
      pop  = live && !ctl.wr_rd;
   end
endmodule

// File: rtl/gray_sync.sv
module gray_sync #(
   parameter int WIDTH  = 7,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stage[s] <= '0;
            else if (s == 0)
               stage[s] <= d;
            else
               stage[s] <= stage[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = stage[STAGES-1];
endmodule

// File: rtl/cdc_lane.sv
module cdc_lane #(
   parameter int DW          = 36,
   parameter int DEPTH       = 64,
   parameter int AE_OFFSET   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          wrst_n,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   output logic          full,
   input  logic          rclk,
   input  logic          rrst_n,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          nearly_empty_n
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   generate
      if (DEPTH != (1 << AW)) begin : g_bad_depth
         $error("cdc_lane: DEPTH must be a power of two");
      end
      if (DEPTH < 4) begin : g_small_depth
         $error("cdc_lane: DEPTH must be at least 4");
      end
      if (AE_OFFSET < 1 || AE_OFFSET >= DEPTH) begin : g_bad_offset
         $error("cdc_lane: AE_OFFSET out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("cdc_lane: SYNC_STAGES must be at least 2");
      end
   endgenerate

   function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [PW-1:0] from_gray(input logic [PW-1:0] g);
      logic [PW-1:0] b;
      b[PW-1] = g[PW-1];
      for (int i = PW - 2; i >= 0; i--)
         b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wbin, wgray, rbin, rgray;
   logic [PW-1:0] rgray_w, wgray_r, count;
   logic          push_ok, pop_ok;

   // writer domain
   assign push_ok = push && !full;
   assign full    = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});

   always_ff @(posedge wclk or negedge wrst_n) begin
      if (!wrst_n) begin
         wbin  <= '0;
         wgray <= '0;
      end else if (push_ok) begin
         wbin  <= wbin + 1'b1;
         wgray <= to_gray(wbin + 1'b1);
      end
   end

   always_ff @(posedge wclk) begin
      if (push_ok)
         mem[wbin[AW-1:0]] <= wdata;
   end

   gray_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
      .clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_w)
   );

   // reader domain
   gray_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
      .clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_r)
   );

   assign count          = from_gray(wgray_r) - rbin;
   assign empty          = (count == '0);
   assign nearly_empty_n = (count > PW'(AE_OFFSET));
   assign pop_ok         = pop && !empty;
   assign rdata          = mem[rbin[AW-1:0]];

   always_ff @(posedge rclk or negedge rrst_n) begin
      if (!rrst_n) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (pop_ok) begin
         rbin  <= rbin + 1'b1;
         rgray <= to_gray(rbin + 1'b1);
      end
   end
endmodule

// File: rtl/bidir_fifo_pair.sv
module bidir_fifo_pair
   import fifo_pair_pkg::*;
#(
   parameter int DW          = 36,
   parameter int DEPTH       = 64,
   parameter int AE_OFFSET   = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk_a,
   input  logic          rst_a_n,
   input  logic          sel_a_n,
   input  logic          wr_rd_a,
   input  logic          mbox_a,
   input  logic          en_a,
   input  logic [DW-1:0] din_a,
   output logic [DW-1:0] dout_a,
   output logic          full_a,
   output logic          empty_a,
   output logic          nearly_empty_n_a,
   input  logic          clk_b,
   input  logic          rst_b_n,
   input  logic          sel_b_n,
   input  logic          wr_rd_b,
   input  logic          mbox_b,
   input  logic          en_b,
   input  logic [DW-1:0] din_b,
   output logic [DW-1:0] dout_b,
   output logic          full_b,
   output logic          empty_b,
   output logic          nearly_empty_n_b
);
   port_ctl_t ctl_a, ctl_b;
   logic      push_a, pop_a, push_b, pop_b;

   assign ctl_a = '{sel_n: sel_a_n, wr_rd: wr_rd_a, mbox: mbox_a, en: en_a};
   assign ctl_b = '{sel_n: sel_b_n, wr_rd: wr_rd_b, mbox: mbox_b, en: en_b};

   port_decode u_dec_a (.ctl(ctl_a), .push(push_a), .pop(pop_a));
   port_decode u_dec_b (.ctl(ctl_b), .push(push_b), .pop(pop_b));

   cdc_lane #(.DW(DW), .DEPTH(DEPTH), .AE_OFFSET(AE_OFFSET),
              .SYNC_STAGES(SYNC_STAGES)) u_lane_ab (
      .wclk(clk_a), .wrst_n(rst_a_n), .push(push_a), .wdata(din_a), .full(full_a),
      .rclk(clk_b), .rrst_n(rst_b_n), .pop(pop_b), .rdata(dout_b),
      .empty(empty_b), .nearly_empty_n(nearly_empty_n_b)
   );

   cdc_lane #(.DW(DW), .DEPTH(DEPTH), .AE_OFFSET(AE_OFFSET),
              .SYNC_STAGES(SYNC_STAGES)) u_lane_ba (
      .wclk(clk_b), .wrst_n(rst_b_n), .push(push_b), .wdata(din_b), .full(full_b),
      .rclk(clk_a), .rrst_n(rst_a_n), .pop(pop_a), .rdata(dout_a),
      .empty(empty_a), .nearly_empty_n(nearly_empty_n_a)
   );
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk #(
   parameter int DW = 36
) (
   input logic          clk_a,
   input logic          rst_a_n,
   input logic          sel_a_n,
   input logic          wr_rd_a,
   input logic          mbox_a,
   input logic          en_a,
   input logic [DW-1:0] dout_a,
   input logic          full_a,
   input logic          empty_a,
   input logic          nearly_empty_n_a,
   input logic          clk_b,
   input logic          rst_b_n,
   input logic          sel_b_n,
   input logic          wr_rd_b,
   input logic          mbox_b,
   input logic          en_b,
   input logic [DW-1:0] dout_b,
   input logic          full_b,
   input logic          empty_b,
   input logic          nearly_empty_n_b
);
   logic req_a, req_b;
   assign req_a = !sel_a_n && !mbox_a && en_a;
   assign req_b = !sel_b_n && !mbox_b && en_b;

   // R10
   ae_under_empty_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      empty_b |-> !nearly_empty_n_b);
   // R10
   ae_under_empty_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      empty_a |-> !nearly_empty_n_a);
   // R2
   head_hold_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n || !rst_a_n)
      (!empty_b && !(req_b && !wr_rd_b)) |=> $stable(dout_b));
   // R3
   head_hold_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n || !rst_b_n)
      (!empty_a && !(req_a && !wr_rd_a)) |=> $stable(dout_a));
   // R5
   full_rise_a_chk: assert property (@(posedge clk_a) disable iff (!rst_a_n)
      $rose(full_a) |-> $past(req_a && wr_rd_a));
   // R5
   full_rise_b_chk: assert property (@(posedge clk_b) disable iff (!rst_b_n)
      $rose(full_b) |-> $past(req_b && wr_rd_b));
   // R9
   reset_flags_b_chk: assert property (@(posedge clk_b)
      !rst_b_n |-> (empty_b && !nearly_empty_n_b));
   // R9
   reset_flags_a_chk: assert property (@(posedge clk_a)
      !rst_a_n |-> (empty_a && !nearly_empty_n_a));
endmodule

bind bidir_fifo_pair fifo_pair_chk #(.DW(DW)) u_chk (.*);

// File: tb/bidir_fifo_pair_bench.sv
`timescale 1ns/1ps
module bidir_fifo_pair_bench;
   localparam int DW = 36;
   localparam int DEPTH = 64;
   localparam int AEO = 8;

   logic clk_a = 0, clk_b = 0;
   logic rst_a_n = 0, rst_b_n = 0;
   logic sel_a_n = 1, wr_rd_a = 0, mbox_a = 0, en_a = 0;
   logic sel_b_n = 1, wr_rd_b = 0, mbox_b = 0, en_b = 0;
   logic [DW-1:0] din_a = '0, din_b = '0, dout_a, dout_b;
   logic full_a, empty_a, nearly_empty_n_a, full_b, empty_b, nearly_empty_n_b;

   int total = 0, fails = 0;
   logic [DW-1:0] q_ab[$];
   logic [DW-1:0] q_ba[$];

   always #10 clk_a = ~clk_a;
   always #13.5 clk_b = ~clk_b;

   bidir_fifo_pair u_bidir_fifo_pair (.*);

   task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive_a(input logic s, input logic w, input logic m, input logic e,
                          input logic [DW-1:0] d);
      @(negedge clk_a);
      sel_a_n = s; wr_rd_a = w; mbox_a = m; en_a = e; din_a = d;
      @(negedge clk_a);
      sel_a_n = 1; en_a = 0; mbox_a = 0;
   endtask

   task automatic drive_b(input logic s, input logic w, input logic m, input logic e,
                          input logic [DW-1:0] d);
      @(negedge clk_b);
      sel_b_n = s; wr_rd_b = w; mbox_b = m; en_b = e; din_b = d;
      @(negedge clk_b);
      sel_b_n = 1; en_b = 0; mbox_b = 0;
   endtask

   task automatic push_a(input logic [DW-1:0] d);
      drive_a(0, 1, 0, 1, d);
      q_ab.push_back(d);
   endtask

   task automatic push_b(input logic [DW-1:0] d);
      drive_b(0, 1, 0, 1, d);
      q_ba.push_back(d);
   endtask

   // monitor side: wait for data, compare head against the scoreboard, then pop
   task automatic pop_b(input string req);
      logic [DW-1:0] exp;
      int n = 0;
      @(negedge clk_b);
      while (empty_b && n < 50) begin @(negedge clk_b); n++; end
      exp = (q_ab.size() > 0) ? q_ab.pop_front() : '0;
      check(!empty_b && dout_b == exp, req, dout_b, exp);
      sel_b_n = 0; wr_rd_b = 0; mbox_b = 0; en_b = 1;
      @(negedge clk_b);
      sel_b_n = 1; en_b = 0;
   endtask

   task automatic pop_a(input string req);
      logic [DW-1:0] exp;
      int n = 0;
      @(negedge clk_a);
      while (empty_a && n < 50) begin @(negedge clk_a); n++; end
      exp = (q_ba.size() > 0) ? q_ba.pop_front() : '0;
      check(!empty_a && dout_a == exp, req, dout_a, exp);
      sel_a_n = 0; wr_rd_a = 0; mbox_a = 0; en_a = 1;
      @(negedge clk_a);
      sel_a_n = 1; en_a = 0;
   endtask

   task automatic wait_b(input int n);
      repeat (n) @(negedge clk_b);
   endtask

   task automatic wait_a(input int n);
      repeat (n) @(negedge clk_a);
   endtask

   initial begin
      #400000;
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      int first_high;
      // R9 reset state
      #55;
      check(empty_b && !nearly_empty_n_b, "R9 reset B flags", {empty_b, nearly_empty_n_b}, 2'b10);
      check(empty_a && !nearly_empty_n_a, "R9 reset A flags", {empty_a, nearly_empty_n_a}, 2'b10);
      rst_a_n = 1; rst_b_n = 1;
      wait_a(2);
      check(!full_a && !full_b, "R9 full flags after reset", {full_a, full_b}, 2'b00);

      // R1 R2 basic ordered transfer
      push_a(36'h1_1111_0001); push_a(36'h2_2222_0002); push_a(36'h3_3333_0003);
      pop_b("R1 R2 word 0"); pop_b("R2 word 1"); pop_b("R2 word 2");
      wait_b(2);
      check(empty_b, "R2 empty after drain", empty_b, 1);

      // R4 accesses that must do nothing
      drive_a(0, 1, 1, 1, 36'hBAD_0001);
      drive_a(1, 1, 0, 1, 36'hBAD_0002);
      drive_a(0, 1, 0, 0, 36'hBAD_0003);
      wait_b(10);
      check(empty_b, "R4 no push on mailbox/unselected/disabled", empty_b, 1);
      push_a(36'h4_0000_0044);
      wait_b(6);
      drive_b(0, 0, 1, 1, '0);
      wait_b(2);
      check(!empty_b && dout_b == 36'h4_0000_0044, "R4 mailbox read does not pop",
            dout_b, 36'h4_0000_0044);
      pop_b("R4 word kept");

      // R6 pop while empty is ignored
      wait_b(4);
      drive_b(0, 0, 0, 1, '0);
      wait_b(2);
      check(empty_b, "R6 empty after pop of empty", empty_b, 1);
      push_a(36'h5_0000_0055);
      pop_b("R6 pointers intact");
      wait_b(3);
      check(empty_b, "R6 empty after single word", empty_b, 1);

      // R7 R8 threshold and latency
      for (int i = 0; i < AEO; i++) push_a(36'h7_0000_0000 + 36'(i));
      wait_b(10);
      check(!nearly_empty_n_b, "R7 flag low at AE_OFFSET words", nearly_empty_n_b, 0);
      @(negedge clk_a);
      sel_a_n = 0; wr_rd_a = 1; mbox_a = 0; en_a = 1; din_a = 36'h7_0000_00FF;
      @(posedge clk_a);
      q_ab.push_back(36'h7_0000_00FF);
      fork
         begin #1; sel_a_n = 1; en_a = 0; end
      join_none
      first_high = 0;
      for (int n = 1; n <= 4; n++) begin
         @(posedge clk_b); #2;
         if (nearly_empty_n_b && first_high == 0) first_high = n;
      end
      check(first_high == 2 || first_high == 3, "R8 flag rise latency",
            36'(first_high), 36'd2);
      check(nearly_empty_n_b, "R7 flag high at AE_OFFSET+1 words", nearly_empty_n_b, 1);
      pop_b("R7 pop at threshold");
      check(!nearly_empty_n_b, "R7 flag low after pop to AE_OFFSET", nearly_empty_n_b, 0);
      for (int i = 0; i < AEO; i++) pop_b("R2 threshold drain");

      // R5 capacity and ignored push when full
      for (int i = 0; i < DEPTH; i++) push_a(36'hA_0000_0000 + 36'(i));
      wait_a(2);
      check(full_a, "R5 full after 64 pushes", full_a, 1);
      drive_a(0, 1, 0, 1, 36'hD_EAD0_DEAD);
      wait_a(2);
      check(full_a, "R5 still full after rejected push", full_a, 1);
      for (int i = 0; i < DEPTH; i++) pop_b("R5 drain full lane");
      wait_b(10);
      check(empty_b, "R5 rejected push stored nothing", empty_b, 1);
      wait_a(6);
      check(!full_a, "R5 full clears after drain", full_a, 0);

      // R3 mirrored lane and its threshold
      for (int i = 0; i < 10; i++) push_b(36'hB_0000_0000 + 36'(i * 3));
      wait_a(10);
      check(nearly_empty_n_a, "R3 R7 mirrored flag high at 10 words", nearly_empty_n_a, 1);
      for (int i = 0; i < 10; i++) pop_a("R3 mirrored order");
      wait_a(2);
      check(empty_a && !nearly_empty_n_a, "R3 mirrored lane empty",
            {empty_a, nearly_empty_n_a}, 2'b10);

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule